// File: doc/BRIEF.md
# Video Character Overlay Generator

This block draws a grid of text over live video. A host writes character codes into a screen memory, one byte for each cell, with 32 cells in each text row. The generator walks that memory in step with the raster. For every displayed cell it fetches two font bytes from a character ROM and shifts the glyph out on the dot clock. It produces a fill pixel and a key-enable signal that a downstream video keyer uses to insert the text into the picture.

The raster reaches the block as three pulses. A vertical sync pulse starts a field. A horizontal sync pulse marks each new scan line. A text-start pulse marks the left edge of the text area on the current line. An overlay-enable input allows the text onto the keyer outputs. A small register port sets the glyph size, the lines per character, the number of text rows, the first text line, the foreground colour and an optional background box. Typical row counts are 28 (tiny), 14 (small) or 7 (large) on 525-line video, and 32, 16 or 8 on 625-line video.

The pixel output behaves as a stream with a valid flag (`fill_vld_o`) and no ready. The raster cannot be stalled, so the keyer must accept every pixel in the cycle it appears.

Top module: `ovl_char_gen`

## Requirements
- R1: Each text row has 32 cells. The screen address of a cell is row*32 + column, and columns appear left to right on the outputs.
- R2: If the text-start pulse is sampled in cycle H on a text line, pixel d of column c is on the outputs in cycle H + 2 + (c+1)*W + d, where W = 16*scale. The first W output cycles after H+1 are blank while column 0 is prefetched.
- R3: A font line is 16 pixels wide and is fetched as two bytes. The ROM address is {code[7:0], font_line[3:0], half}, where half 0 is the left byte and half 1 is the right byte. Bit 7 of each byte is shown first.
- R4: Register 0 bits [1:0] select the size: 0 is tiny (scale 1), 1 is small (scale 2), and 2 or 3 is large (scale 4). Each font pixel lasts scale dot clocks, and each font line lasts scale scan lines.
- R5: Register 1 bits [3:0] hold the lines per character minus one. Register 2 bits [4:0] hold the text rows minus one. Register 3 holds the first text line S. Counting horizontal sync pulses since vertical sync as k, lines with S <= k < S + rows*lines*scale are text lines. On these lines the font line is ((k-S) mod (lines*scale)) / scale and the row is (k-S) / (lines*scale). On any other line a text-start pulse produces no output.
- R6: Code 0xFF marks an empty cell. Key and fill stay low for the whole cell.
- R7: For a cell that is not empty, register 0 bit 3 (box) selects the key. With box at 0, key follows the glyph bit. With box at 1, key is high for the whole cell.
- R8: Register 0 bit 2 (white) sets the colour. While key is high, fill equals white where the glyph bit is 1 and the inverse of white where it is 0. While key is low, fill is 0.
- R9: While the overlay-enable input is low, key, fill and valid are all low. The outputs are registered, so the enable sampled in cycle t acts on the outputs in cycle t+1.
- R10: `fill_vld_o` is high for exactly the 32*W output cycles of the displayed cells, and key is only ever high while valid is high.
- R11: After reset the outputs are low and the registers hold tiny size, black, no box, 9 lines per character, 28 rows, and first text line 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| hsync_i | input | 1 | One-cycle pulse per scan line |
| vsync_i | input | 1 | One-cycle pulse per field |
| hstart_i | input | 1 | One-cycle pulse at left edge of text area |
| ovl_en_i | input | 1 | Allows overlay onto keyer outputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| ram_addr_o | output | 10 | Screen memory read address |
| ram_data_i | input | 8 | Screen memory data, one cycle after address |
| rom_addr_o | output | 13 | Font ROM read address |
| rom_data_i | input | 8 | Font ROM data, one cycle after address |
| fill_o | output | 1 | Fill pixel |
| key_o | output | 1 | Key enable for the keyer |
| fill_vld_o | output | 1 | Pixel stream valid |

## Verification
A wrong column or row counter shows up as glyphs from the wrong screen address. The whole line shifts or repeats, and this is visible at the first displayed cell, within W+2 cycles of text start. A fault in the font-line or size counters shows on the first scan line where a font line should repeat or advance. A stuck empty-cell flag, or a stuck box or colour decode, corrupts key or fill within one cell. The bench sweeps every output cycle of every line of short fields in each size and colour mode, so each of these faults is caught on the first line where it acts.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int GLYPH_W = 16;
  localparam int LPC_W   = 4;
  localparam int ROW_W   = 5;
  localparam int VST_W   = 8;
  localparam int LINE_W  = 10;
  localparam int HC_W    = 6;

  typedef enum logic [1:0] {
    SZ_TINY  = 2'd0,
    SZ_SMALL = 2'd1,
    SZ_LARGE = 2'd2,
    SZ_HUGE  = 2'd3
  } size_e;

  typedef struct packed {
    size_e              size;
    logic               white;
    logic               box;
    logic [LPC_W-1:0]   lpc_m1;
    logic [ROW_W-1:0]   rows_m1;
    logic [VST_W-1:0]   vstart;
  } ovl_cfg_t;

  function automatic logic [1:0] scale_m1(input size_e s);
    case (s)
      SZ_TINY:  return 2'd0;
      SZ_SMALL: return 2'd1;
      default:  return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/ovl_regs.sv
module ovl_regs
  import ovl_pkg::*;
#(
  parameter int DEF_LPC    = 9,
  parameter int DEF_ROWS   = 28,
  parameter int DEF_VSTART = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output ovl_cfg_t   cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.size    <= SZ_TINY;
      cfg.white   <= 1'b0;
      cfg.box     <= 1'b0;
      cfg.lpc_m1  <= LPC_W'(DEF_LPC - 1);
      cfg.rows_m1 <= ROW_W'(DEF_ROWS - 1);
      cfg.vstart  <= VST_W'(DEF_VSTART);
    end else if (we) begin
      case (addr)
        2'd0: begin
          cfg.size  <= size_e'(wdata[1:0]);
          cfg.white <= wdata[2];
          cfg.box   <= wdata[3];
        end
        2'd1: cfg.lpc_m1  <= wdata[LPC_W-1:0];
        2'd2: cfg.rows_m1 <= wdata[ROW_W-1:0];
        default: cfg.vstart <= wdata[VST_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/ovl_vtiming.sv
module ovl_vtiming
  import ovl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync,
  input  logic             hsync,
  input  ovl_cfg_t         cfg,
  output logic             vact,
  output logic [ROW_W-1:0] row,
  output logic [LPC_W-1:0] fline
);
  logic [LINE_W-1:0] line_cnt;
  logic [1:0]        sub;
  logic              done;
  logic [1:0]        sc_m1;

  assign sc_m1 = scale_m1(cfg.size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      sub      <= '0;
      fline    <= '0;
      row      <= '0;
      vact     <= 1'b0;
      done     <= 1'b0;
    end else if (vsync) begin
      line_cnt <= '0;
      sub      <= '0;
      fline    <= '0;
      row      <= '0;
      vact     <= (cfg.vstart == '0);
      done     <= 1'b0;
    end else if (hsync) begin
      line_cnt <= line_cnt + 1'b1;
      if (vact) begin
        if (sub == sc_m1) begin
          sub <= '0;
          if (fline == cfg.lpc_m1) begin
            fline <= '0;
            if (row == cfg.rows_m1) begin
              row  <= '0;
              vact <= 1'b0;
              done <= 1'b1;
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            fline <= fline + 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end else if (!done && ((line_cnt + 1'b1) == LINE_W'(cfg.vstart))) begin
        vact <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovl_fetch.sv
module ovl_fetch
  import ovl_pkg::*;
#(
  parameter int COLS   = 32,
  parameter int CODE_W = 8,
  parameter int COL_W  = $clog2(COLS),
  parameter int SLOT_W = $clog2(COLS + 1),
  parameter int RAM_AW = ROW_W + COL_W,
  parameter int ROM_AW = CODE_W + LPC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hstart,
  input  logic               vact,
  input  logic [ROW_W-1:0]   row,
  input  logic [LPC_W-1:0]   fline,
  input  size_e              size,
  output logic [RAM_AW-1:0]  ram_addr,
  input  logic [CODE_W-1:0]  ram_data,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [7:0]         rom_data,
  output logic               run,
  output logic [HC_W-1:0]    hcnt,
  output logic [SLOT_W-1:0]  slot,
  output logic               start,
  output logic               load,
  output logic               load_valid,
  output logic [GLYPH_W-1:0] nxt_bits,
  output logic               nxt_empty
);
  logic [HC_W-1:0]   cell_last;
  logic [CODE_W-1:0] code_q;
  logic [7:0]        left_q;
  logic [7:0]        right_q;

  assign cell_last  = HC_W'({scale_m1(size), 4'hF});
  assign start      = hstart && vact;
  assign load       = run && (hcnt == cell_last);
  assign load_valid = slot < SLOT_W'(COLS);
  assign ram_addr   = {row, slot[COL_W-1:0]};
  assign rom_addr   = (hcnt == HC_W'(1)) ? {ram_data, fline, 1'b0}
                                         : {code_q, fline, 1'b1};
  assign nxt_bits   = {left_q, right_q};
  assign nxt_empty  = &code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      hcnt <= '0;
      slot <= '0;
    end else if (start) begin
      run  <= 1'b1;
      hcnt <= '0;
      slot <= '0;
    end else if (run) begin
      if (hcnt == cell_last) begin
        hcnt <= '0;
        if (slot == SLOT_W'(COLS)) run  <= 1'b0;
        else                       slot <= slot + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '1;
      left_q  <= '0;
      right_q <= '0;
    end else if (run) begin
      if (hcnt == HC_W'(1)) code_q  <= ram_data;
      if (hcnt == HC_W'(2)) left_q  <= rom_data;
      if (hcnt == HC_W'(3)) right_q <= rom_data;
    end
  end
endmodule

// File: rtl/ovl_pixout.sv
module ovl_pixout
  import ovl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               load,
  input  logic               load_valid,
  input  logic [GLYPH_W-1:0] nxt_bits,
  input  logic               nxt_empty,
  input  size_e              size,
  input  logic               white,
  input  logic               box,
  input  logic               en,
  output logic               fill,
  output logic               key,
  output logic               vld
);
  logic [GLYPH_W-1:0] shreg;
  logic [1:0]         sc;
  logic               cur_valid;
  logic               cur_empty;
  logic               glyph;
  logic               show;
  logic               key_n;

  assign glyph = shreg[GLYPH_W-1];
  assign show  = en && cur_valid;
  assign key_n = show && !cur_empty && (box || glyph);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      sc        <= '0;
      cur_valid <= 1'b0;
      cur_empty <= 1'b1;
    end else if (start) begin
      cur_valid <= 1'b0;
    end else if (load) begin
      shreg     <= nxt_bits;
      sc        <= '0;
      cur_valid <= load_valid;
      cur_empty <= nxt_empty;
    end else if (sc == scale_m1(size)) begin
      sc    <= '0;
      shreg <= {shreg[GLYPH_W-2:0], 1'b0};
    end else begin
      sc <= sc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= 1'b0;
      key  <= 1'b0;
      vld  <= 1'b0;
    end else begin
      vld  <= show;
      key  <= key_n;
      fill <= key_n && (glyph ? white : !white);
    end
  end
endmodule

// File: rtl/ovl_char_gen.sv
module ovl_char_gen
  import ovl_pkg::*;
#(
  parameter int COLS       = 32,
  parameter int CODE_W     = 8,
  parameter int DEF_LPC    = 9,
  parameter int DEF_ROWS   = 28,
  parameter int DEF_VSTART = 16,
  parameter int COL_W      = $clog2(COLS),
  parameter int RAM_AW     = ROW_W + COL_W,
  parameter int ROM_AW     = CODE_W + LPC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              hstart_i,
  input  logic              ovl_en_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  input  logic [CODE_W-1:0] ram_data_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [7:0]        rom_data_i,
  output logic              fill_o,
  output logic              key_o,
  output logic              fill_vld_o
);
  localparam int SLOT_W = $clog2(COLS + 1);

  ovl_cfg_t           cfg;
  logic               vact;
  logic [ROW_W-1:0]   row;
  logic [LPC_W-1:0]   fline;
  logic               run;
  logic [HC_W-1:0]    hcnt;
  logic [SLOT_W-1:0]  slot;
  logic               start;
  logic               load;
  logic               load_valid;
  logic [GLYPH_W-1:0] nxt_bits;
  logic               nxt_empty;

  ovl_regs #(
    .DEF_LPC(DEF_LPC), .DEF_ROWS(DEF_ROWS), .DEF_VSTART(DEF_VSTART)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .cfg(cfg)
  );

  ovl_vtiming u_vtim (
    .clk(clk), .rst_n(rst_n), .vsync(vsync_i), .hsync(hsync_i), .cfg(cfg),
    .vact(vact), .row(row), .fline(fline)
  );

  ovl_fetch #(
    .COLS(COLS), .CODE_W(CODE_W), .COL_W(COL_W), .SLOT_W(SLOT_W),
    .RAM_AW(RAM_AW), .ROM_AW(ROM_AW)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .hstart(hstart_i), .vact(vact), .row(row),
    .fline(fline), .size(cfg.size), .ram_addr(ram_addr_o),
    .ram_data(ram_data_i), .rom_addr(rom_addr_o), .rom_data(rom_data_i),
    .run(run), .hcnt(hcnt), .slot(slot), .start(start), .load(load),
    .load_valid(load_valid), .nxt_bits(nxt_bits), .nxt_empty(nxt_empty)
  );

  ovl_pixout u_pix (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load),
    .load_valid(load_valid), .nxt_bits(nxt_bits), .nxt_empty(nxt_empty),
    .size(cfg.size), .white(cfg.white), .box(cfg.box), .en(ovl_en_i),
    .fill(fill_o), .key(key_o), .vld(fill_vld_o)
  );
endmodule

// File: rtl/ovl_char_gen_chk.sv
module ovl_char_gen_chk #(
  parameter int ROM_AW = 13,
  parameter int HC_W   = 6,
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hstart_i,
  input logic              ovl_en_i,
  input logic              fill_o,
  input logic              key_o,
  input logic              fill_vld_o,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic              run,
  input logic [HC_W-1:0]   hcnt,
  input logic [SLOT_W-1:0] slot,
  input logic              vact
);
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_en_i |=> (!key_o && !fill_o && !fill_vld_o));

  p_key_in_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    key_o |-> fill_vld_o);

  p_fill_needs_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o |-> key_o);

  p_font_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hcnt == HC_W'(1)) |=>
      (rom_addr_o[0] && rom_addr_o[ROM_AW-1:1] == $past(rom_addr_o[ROM_AW-1:1])));

  p_lead_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && slot == '0) |=> !fill_vld_o);

  p_idle_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hstart_i && !vact && !run) |=> !run);
endmodule

bind ovl_char_gen ovl_char_gen_chk #(
  .ROM_AW(ROM_AW), .HC_W(ovl_pkg::HC_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hstart_i(hstart_i), .ovl_en_i(ovl_en_i),
  .fill_o(fill_o), .key_o(key_o), .fill_vld_o(fill_vld_o),
  .rom_addr_o(rom_addr_o), .run(run), .hcnt(hcnt), .slot(slot), .vact(vact)
);

// File: tb/sim_ovl_char_gen.sv
`timescale 1ns/1ps
module sim_ovl_char_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, hstart = 1'b0, en = 1'b0;
  logic we = 1'b0;
  logic [1:0] waddr = '0;
  logic [7:0] wdata = '0;
  logic [9:0] ram_addr;
  logic [7:0] ram_q;
  logic [12:0] rom_addr;
  logic [7:0] rom_q;
  logic fill, key, vld;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] scr [0:1023];

  int c_size, c_white, c_box, c_en, c_lpc, c_rows, c_vst;

  always #2.5 clk = ~clk;

  ovl_char_gen u0 (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .hstart_i(hstart), .ovl_en_i(en), .reg_we_i(we), .reg_addr_i(waddr),
    .reg_wdata_i(wdata), .ram_addr_o(ram_addr), .ram_data_i(ram_q),
    .rom_addr_o(rom_addr), .rom_data_i(rom_q), .fill_o(fill), .key_o(key),
    .fill_vld_o(vld)
  );

  function automatic logic [7:0] font_byte(input logic [12:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd73;
    return t[7:0] ^ {3'b0, a[12:8]} ^ 8'hA5;
  endfunction

  always_ff @(posedge clk) begin
    ram_q <= scr[ram_addr];
    rom_q <= font_byte(rom_addr);
  end

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s: {vld,key,fill} actual %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic fill_screen(input int seed);
    for (int i = 0; i < 1024; i++) begin
      logic [7:0] v;
      v = 8'((i * 29 + seed * 7) & 255);
      if (v == 8'hFF) v = 8'hFE;
      if (((i * 13 + seed) % 5) == 0) v = 8'hFF;
      scr[i] = v;
    end
  endtask

  task automatic check_line(input int k);
    int sc, w, n, v, row, fl;
    bit shown;
    sc = (c_size == 0) ? 1 : (c_size == 1) ? 2 : 4;
    w = 16 * sc;
    n = c_rows * c_lpc * sc;
    shown = (k >= c_vst) && (k < c_vst + n);
    v = k - c_vst;
    row = shown ? v / (c_lpc * sc) : 0;
    fl = shown ? (v % (c_lpc * sc)) / sc : 0;
    hstart = 1'b1;
    for (int j = 1; j <= 33 * w + 3; j++) begin
      int x, s, d, c;
      logic [7:0] code;
      logic [15:0] bits;
      logic b, ek, ef, ev;
      string req;
      @(negedge clk);
      if (j == 1) hstart = 1'b0;
      x = j - 2;
      s = (x >= 0) ? x / w : -1;
      d = (x >= 0) ? x % w : 0;
      ev = 0; ek = 0; ef = 0;
      if (!shown) req = "R5";
      else if (s < 1) req = "R2";
      else if (s > 32) req = "R10";
      else begin
        c = s - 1;
        code = scr[row * 32 + c];
        bits = {font_byte({code, 4'(fl), 1'b0}), font_byte({code, 4'(fl), 1'b1})};
        b = bits[15 - d / sc];
        ev = (c_en != 0);
        ek = ev && (code != 8'hFF) && ((c_box != 0) || b);
        ef = ek && (b ? (c_white != 0) : (c_white == 0));
        if (c_en == 0) req = "R9";
        else if (code == 8'hFF) req = "R6";
        else if (c_size != 0) req = "R4";
        else if (c_box != 0) req = "R7";
        else req = "R1 R3 R8";
      end
      check(req, {vld, key, fill}, {ev, ek, ef});
    end
  endtask

  task automatic run_frame(input int last_k);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    for (int k = 1; k <= last_k; k++) begin
      hsync = 1'b1;
      @(negedge clk);
      hsync = 1'b0;
      repeat (3) @(negedge clk);
      check_line(k);
    end
  endtask

  task automatic mode(input int sz, input int wh, input int bx, input int e,
                      input int lpc, input int rows, input int seed);
    int sc;
    c_size = sz; c_white = wh; c_box = bx; c_en = e;
    c_lpc = lpc; c_rows = rows; c_vst = 2;
    sc = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    fill_screen(seed);
    wr(2'd0, 8'(sz | (wh << 2) | (bx << 3)));
    wr(2'd1, 8'(lpc - 1));
    wr(2'd2, 8'(rows - 1));
    wr(2'd3, 8'(c_vst));
    en = (e != 0);
    run_frame(c_vst + rows * lpc * sc);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R11 reset", {vld, key, fill}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset idle", {vld, key, fill}, 3'b000);
    // R11: default registers (tiny, black, no box, 9 lines, 28 rows, start 16)
    c_size = 0; c_white = 0; c_box = 0; c_en = 1;
    c_lpc = 9; c_rows = 28; c_vst = 16;
    fill_screen(3);
    en = 1'b1;
    run_frame(17);
    mode(0, 1, 0, 1, 2, 2, 1);
    mode(0, 0, 0, 1, 2, 2, 2);
    mode(0, 1, 1, 1, 2, 2, 4);
    mode(0, 0, 1, 1, 3, 3, 5);
    mode(1, 1, 0, 1, 2, 2, 6);
    mode(2, 0, 1, 1, 2, 2, 8);
    mode(0, 1, 1, 0, 2, 2, 9);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule